// File: doc/BRIEF.md
# UART Transmitter with Pin Routing

This block turns a written character into an asynchronous serial frame and drives it onto the transmit pin. A character is accepted through a one-cycle write strobe while the block is ready. The frame is then shifted out at one bit per sixteen baud ticks, where the baud tick is a one-cycle enable at sixteen times the bit rate. Characters are 8 or 9 data bits long. Hardware parity can be switched on, and it then takes the place of the character's most significant data bit rather than lengthening the frame.

The same block owns the routing that chooses what the receiver listens to. Two configuration bits select one of three routings:
- Separate transmit and receive pins.
- An internal loop in which the transmitter feeds the receiver and the transmit pin stays idle.
- A single-wire arrangement in which the transmit pin is shared. The transmitter only drives that pin while a frame is in flight, and the receiver hears whatever is on the pin.

Top module: `uart_tx_route`

## Requirements
- R1: With 9-bit mode clear, a frame is a start bit (0), data bits 0 to 7 with bit 0 first, and one stop bit (1), for 10 bits in all.
- R2: With 9-bit mode set, a frame is a start bit (0), data bits 0 to 7 with bit 0 first, then data bit 8, then one stop bit (1), for 11 bits in all.
- R3: With parity enabled, the last data bit of the frame is the generated parity bit and the written value of that bit is dropped. That bit is bit 7 in 8-bit mode, computed over bits 0 to 6, and bit 8 in 9-bit mode, computed over bits 0 to 7.
- R4: Parity type 0 makes the number of ones in the character, parity bit included, even. Parity type 1 makes that number odd.
- R5: Every bit of the frame holds the line for exactly 16 baud ticks, whatever the spacing of the ticks. The line does not change between ticks.
- R6: Ready is high out of reset and between frames, and the serial line is then high. Ready goes low in the cycle after a write is accepted, with the start bit on the line. Ready returns high in the cycle after the 16th tick of the stop bit.
- R7: A write strobe while ready is low is ignored, and the frame in progress continues unchanged.
- R8: With loop enable clear, the pin drive carries the transmitter output, the output-enable is high, and the receiver line follows the receive pin.
- R9: With loop enable set and receiver source clear, the receiver line carries the transmitter output, the receive pin is ignored, and the pin drive is held high.
- R10: With loop enable and receiver source both set, the output-enable is high only while a frame is in flight. The receiver line then follows the sensed level of the transmit pin.
- R11: With loop enable clear, the receiver source bit has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| wr_valid | input | 1 | Write strobe for a new character |
| wr_data | input | 9 | Character; bit 8 is used only in 9-bit mode |
| cfg_nine | input | 1 | 1 selects 9-bit characters |
| cfg_par_en | input | 1 | 1 enables parity generation |
| cfg_par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| cfg_loop | input | 1 | 1 selects one of the loop routings |
| cfg_rx_src | input | 1 | With loop set: 0 selects internal loop, 1 selects single-wire |
| rxd_pin | input | 1 | Level sensed on the receive pin |
| txd_pin_in | input | 1 | Level sensed on the transmit pin |
| txd_out | output | 1 | Drive value for the transmit pin |
| txd_oe | output | 1 | Output-enable for the transmit pin |
| rx_line | output | 1 | Serial line delivered to the receiver |
| tx_ready | output | 1 | High when a new character can be written |

## Verification
The bench builds the block with its default of 16 ticks per bit. It sweeps every combination of character length, parity enable and parity type over a dozen computed data words, including all-zeros and all-ones, and checks each bit at mid-bit against a frame assembled arithmetically. Running some frames with ticks on every cycle and others with sparse ticks brings both tick spacing and the exact cycle of the return to ready within reach. Frames are also sent in each of the three routings while the bench toggles the receive pin, toggles an external driver on the shared pin, and strobes a second write mid-frame.

// File: rtl/uart_tx_route.sv
module uart_tx_route #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       wr_valid,
  input  logic [8:0] wr_data,
  input  logic       cfg_nine,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_loop,
  input  logic       cfg_rx_src,
  input  logic       rxd_pin,
  input  logic       txd_pin_in,
  output logic       txd_out,
  output logic       txd_oe,
  output logic       rx_line,
  output logic       tx_ready
);

  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] TMAX = CW'(TICKS_PER_BIT - 1);

  logic          busy;
  logic          nine_q;
  logic [10:0]   shreg;
  logic [CW-1:0] tcnt;
  logic [3:0]    bcnt;

  wire accept   = wr_valid & ~busy;
  wire bit_done = busy & baud_tick & (tcnt == TMAX);
  wire last_bit = (bcnt == (nine_q ? 4'd10 : 4'd9));

  wire msb8 = cfg_par_en ? (^wr_data[6:0] ^ cfg_par_odd) : wr_data[7];
  wire msb9 = cfg_par_en ? (^wr_data[7:0] ^ cfg_par_odd) : wr_data[8];

  logic [10:0] load;
  assign load = cfg_nine ? {1'b1, msb9, wr_data[7:0], 1'b0}
                         : {2'b11, msb8, wr_data[6:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      nine_q <= 1'b0;
      shreg  <= '1;
      tcnt   <= '0;
      bcnt   <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      nine_q <= cfg_nine;
      shreg  <= load;
      tcnt   <= '0;
      bcnt   <= '0;
    end else if (busy && baud_tick) begin
      if (tcnt == TMAX) begin
        tcnt <= '0;
        if (last_bit) begin
          busy  <= 1'b0;
          shreg <= '1;
        end else begin
          shreg <= {1'b1, shreg[10:1]};
          bcnt  <= bcnt + 4'd1;
        end
      end else begin
        tcnt <= tcnt + CW'(1);
      end
    end
  end

  wire line = busy ? shreg[0] : 1'b1;
  wire internal_loop = cfg_loop & ~cfg_rx_src;
  wire single_wire   = cfg_loop & cfg_rx_src;

  assign tx_ready = ~busy;
  assign txd_out  = internal_loop ? 1'b1 : line;
  assign txd_oe   = single_wire ? busy : 1'b1;
  assign rx_line  = !cfg_loop ? rxd_pin : (single_wire ? txd_pin_in : line);

  assert_start_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && tx_ready) |=> (!tx_ready && !line));

  assert_idle_line_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (line && txd_out));

  assert_bit_held_between_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !bit_done) |=> $stable(line));

  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && wr_valid && !bit_done) |=> ($stable(shreg) && !tx_ready));

  assert_loop_pin_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_loop && !cfg_rx_src) |-> (txd_out && txd_oe));

  assert_single_wire_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_loop && cfg_rx_src) |-> (txd_oe == !tx_ready));

endmodule

// File: tb/tb_uart_tx_route.sv
module tb_uart_tx_route;
  logic clk = 0;
  logic rst_n = 0;
  logic baud_tick = 0, wr_valid = 0;
  logic [8:0] wr_data = '0;
  logic cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_loop = 0, cfg_rx_src = 0;
  logic rxd_pin = 1, ext_drv = 1;
  logic txd_pin_in, txd_out, txd_oe, rx_line, tx_ready;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign txd_pin_in = txd_oe ? txd_out : ext_drv;

  uart_tx_route dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_valid(wr_valid),
    .wr_data(wr_data), .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_loop(cfg_loop), .cfg_rx_src(cfg_rx_src),
    .rxd_pin(rxd_pin), .txd_pin_in(txd_pin_in), .txd_out(txd_out),
    .txd_oe(txd_oe), .rx_line(rx_line), .tx_ready(tx_ready));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] exp_frame(input logic nine, input logic pe,
                                            input logic odd, input logic [8:0] d);
    logic [10:0] f;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    if (nine) begin
      f[9] = pe ? ((^d[7:0]) ^ odd) : d[8];
      f[10] = 1'b1;
    end else begin
      if (pe) f[8] = (^d[6:0]) ^ odd;
      f[9] = 1'b1;
    end
    return f;
  endfunction

  // mode 0: separate pins, 1: internal loop, 2: single-wire
  task automatic run_frame(input int mode, input logic nine, input logic pe,
                           input logic odd, input logic [8:0] d, input int period);
    logic [10:0] f;
    int nbits, ticks, cyc, last_chk;
    logic obs;
    f = exp_frame(nine, pe, odd, d);
    nbits = nine ? 11 : 10;
    cfg_nine = nine; cfg_par_en = pe; cfg_par_odd = odd;
    cfg_loop = (mode != 0); cfg_rx_src = (mode == 2);
    baud_tick = 0;
    @(negedge clk);
    chk("R6 ready before write", tx_ready, 1'b1);
    wr_valid = 1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0;
    ticks = 0; cyc = 0; last_chk = -1;
    while (ticks < 16 * nbits) begin
      obs = (mode == 1) ? rx_line : txd_out;
      if (ticks % 16 == 8 && ticks / 16 != last_chk) begin
        last_chk = ticks / 16;
        chk(nine ? "R2 R3 R4 frame bit" : "R1 R3 R4 frame bit", obs, f[ticks/16]);
        chk("R6 ready low in frame", tx_ready, 1'b0);
        if (mode == 1) chk("R9 pin held high", txd_out, 1'b1);
        if (mode == 2) begin
          chk("R10 oe in frame", txd_oe, 1'b1);
          chk("R10 rx from pin", rx_line, f[ticks/16]);
        end
        if (mode == 0) chk("R8 rx from rxd pin", rx_line, rxd_pin);
      end
      if (ticks == 16 * nbits - 1 && period > 1)
        chk("R5 R6 ready still low", tx_ready, 1'b0);
      wr_valid = (cyc == 20);
      wr_data = ~d;
      baud_tick = ((cyc % period) == period - 1);
      rxd_pin = ~rxd_pin;
      @(posedge clk);
      if (baud_tick) ticks++;
      cyc++;
      @(negedge clk);
      wr_valid = 0;
      baud_tick = 0;
    end
    chk("R5 R6 ready after stop", tx_ready, 1'b1);
    chk("R6 line idle", (mode == 1) ? rx_line : txd_out, 1'b1);
    if (mode == 2) chk("R10 oe released", txd_oe, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset ready", tx_ready, 1'b1);
    chk("R6 reset line", txd_out, 1'b1);
    rst_n = 1;
    @(negedge clk);
    // routing when idle
    for (int s = 0; s < 2; s++) begin
      cfg_loop = 0; cfg_rx_src = s[0];
      for (int v = 0; v < 2; v++) begin
        rxd_pin = v[0];
        @(negedge clk);
        chk("R8 R11 rx follows rxd", rx_line, v[0]);
        chk("R8 R11 oe high", txd_oe, 1'b1);
        chk("R11 txd idle", txd_out, 1'b1);
      end
    end
    cfg_loop = 1; cfg_rx_src = 0;
    for (int v = 0; v < 2; v++) begin
      rxd_pin = v[0];
      @(negedge clk);
      chk("R9 rxd ignored", rx_line, 1'b1);
    end
    cfg_loop = 1; cfg_rx_src = 1;
    for (int v = 0; v < 2; v++) begin
      ext_drv = v[0];
      @(negedge clk);
      chk("R10 released idle", txd_oe, 1'b0);
      chk("R10 rx hears pin", rx_line, v[0]);
    end
    ext_drv = 1;
    // full sweep in internal loop mode, tick every cycle
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 12; k++) begin
        logic [8:0] d;
        d = (k == 0) ? 9'h000 : (k == 1) ? 9'h1FF : 9'((k * 91 + 19) * 7);
        run_frame(1, c[2], c[1], c[0], d, 1);
      end
    // other routings and sparse ticks
    for (int m = 0; m < 3; m++) begin
      run_frame(m, 1'b0, 1'b1, 1'b1, 9'h0A5, 1);
      run_frame(m, 1'b1, 1'b0, 1'b0, 9'h15A, 3);
      run_frame(m, 1'b1, 1'b1, 1'b0, 9'h0F3, 2);
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule